// File: doc/BRIEF.md
# Qualified-State Sequence Trigger

This block watches a sampled bus and decides when a capture should be triggered. It runs on the system clock, but it only evaluates a bus state on cycles where the target's state strobe is high. Each such cycle counts as one qualified state. Three masked comparators (first, second and guard pattern) classify every qualified state. A sequencer then checks the chosen sequence of matches. Depending on the mode, it uses a shared occurrence limit `count_n` and a time window `time_lim`, which is measured against a free-running cycle counter.

When the sequence completes, `trig` goes high for exactly one cycle. After that the engine stays silent until a `restart` pulse clears all sequence state. When arming is enabled, the engine ignores every state until an `arm` pulse has been seen. Typical use: a host sets up the mode, the patterns and the limits, pulses `restart`, optionally pulses `arm`, and waits for the trigger.

Top module: `seqtrig_top`

## Requirements
- R1: A comparator matches when every bus bit whose mask bit is 1 equals the same bit of its pattern value; bus bits whose mask bit is 0 are ignored.
- R2: Modes 0 (any state) and 1 (strobe count) fire on the N-th qualified state whatever its value; a `count_n` of 0 or 1 fires on the first qualified state.
- R3: Mode 2 fires on the N-th qualified state that matches the first pattern; those matches need not be adjacent.
- R4: Mode 3 fires when the first pattern matches on N qualified states in a row; any qualified state that does not match restarts the run from zero.
- R5: Mode 4 fires on a second-pattern match at any qualified state after the one on which the first pattern matched.
- R6: Mode 5 fires only when the first qualified state that no longer matches the first pattern matches the second pattern; if it does not, the engine goes back to waiting for the first pattern.
- R7: Mode 6 fires when the first-then-second sequence has completed N times; a guard-pattern match while the engine waits for the second pattern cancels that attempt.
- R8: Mode 7 fires when the second pattern follows the first with fewer than N qualified states in between; mode 8 fires when more than N states lie in between; a failed comparison returns the engine to waiting for the first pattern, and a repeated first-pattern match restarts the gap count.
- R9: With P1 sampled at edge k, mode 9 fires on a second-pattern state sampled at edge k+m with m <= `time_lim`, and the window closes without firing once m exceeds the limit. Mode 10 fires at edge k+`time_lim`+1 unless a second-pattern state arrives first, which cancels the attempt. `time_lim` must be below all-ones.
- R10: Mode 11 counts qualified states on which both the first and the second pattern match, and mode 12 counts states on which either matches; each fires on the N-th such state.
- R11: While `arm_en` is 1, no state is evaluated until after the edge that samples `arm` high. The state sampled at that same edge is not evaluated, and `restart` disarms the engine.
- R12: Cycles with `strobe` low change no comparator-driven count or sequence state; only the time counter advances on every clock.
- R13: `trig` goes high in the cycle after the edge that completes the sequence and lasts one cycle. After that no further trigger occurs until a `restart` pulse, which clears all sequence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of all sequence, count, arm and hold-off state |
| arm_en | input | 1 | When 1, evaluation waits for an arm pulse |
| arm | input | 1 | Arm pulse |
| strobe | input | 1 | Target state strobe; qualifies the bus sample |
| bus | input | W | Captured bus state |
| mode | input | 4 | Sequence mode select (0 to 12) |
| p1_val | input | W | First pattern value |
| p1_msk | input | W | First pattern mask (1 = compare) |
| p2_val | input | W | Second pattern value |
| p2_msk | input | W | Second pattern mask |
| p3_val | input | W | Guard pattern value |
| p3_msk | input | W | Guard pattern mask |
| count_n | input | CW | Occurrence count or gap limit |
| time_lim | input | TW | Time window in system clocks |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The counting modes are driven with streams where matching states are mixed with non-matching states and with unstrobed copies of the pattern. This separates counting that skips gaps, counting that needs an unbroken run, and wrongly counting states with no strobe. The ordered modes get sequences in which the second pattern comes too early, the run of first patterns is broken, or the guard pattern lands mid-attempt, so that each cancel path has to be taken before the firing path is reached. The gap and time modes are tried with values on both sides of the limit, which pins down the exact comparison and the cycle of the trigger. The masked, combined and armed cases separate don't-care bits, AND versus OR decoding, and the effect of the arming edge.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

  typedef enum logic [3:0] {
    MD_ANY        = 4'd0,
    MD_STROBES    = 4'd1,
    MD_P1_CNT     = 4'd2,
    MD_P1_RUN     = 4'd3,
    MD_P1_THEN_P2 = 4'd4,
    MD_P1_NEXT_P2 = 4'd5,
    MD_P1P2_GUARD = 4'd6,
    MD_GAP_SHORT  = 4'd7,
    MD_GAP_LONG   = 4'd8,
    MD_P2_EARLY   = 4'd9,
    MD_P2_OVERDUE = 4'd10,
    MD_BOTH       = 4'd11,
    MD_EITHER     = 4'd12
  } seq_mode_e;

  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_SEEN = 1'b1
  } seq_phase_e;

endpackage

// File: rtl/seqtrig_cmp.sv
module seqtrig_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] bus,
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  output logic         hit
);

  function automatic logic masked_eq(input logic [W-1:0] b,
                                     input logic [W-1:0] v,
                                     input logic [W-1:0] m);
    return ((b ^ v) & m) == '0;
  endfunction

  assign hit = masked_eq(bus, val, msk);

endmodule

// File: rtl/seqtrig_timer.sv
module seqtrig_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [TW-1:0] elapsed
);

  logic [TW-1:0] now_q;
  logic [TW-1:0] stamp_q;

  function automatic logic [TW-1:0] since(input logic [TW-1:0] cur,
                                          input logic [TW-1:0] start);
    return cur - start;
  endfunction

  // free-running: advances on every system clock, strobe or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q   <= '0;
      stamp_q <= '0;
    end else begin
      now_q <= now_q + {{(TW-1){1'b0}}, 1'b1};
      if (load) stamp_q <= now_q;
    end
  end

  assign elapsed = since(now_q, stamp_q);

endmodule

// File: rtl/seqtrig_fsm.sv
module seqtrig_fsm
  import seqtrig_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          arm_en,
  input  logic          arm,
  input  logic          strobe,
  input  logic [3:0]    mode,
  input  logic          m1,
  input  logic          m2,
  input  logic          m3,
  input  logic [CW-1:0] count_n,
  input  logic [TW-1:0] time_lim,
  input  logic [TW-1:0] elapsed,
  output logic          load_stamp,
  output logic          qual,
  output logic          fire,
  output logic          armed,
  output logic          done,
  output logic          trig
);

  localparam int GW = CW + 1;

  seq_mode_e        md;
  seq_phase_e       ph_q, ph_n;
  logic [CW-1:0]    occ_q, occ_n;
  logic [GW-1:0]    gap_q, gap_n;
  logic             armed_q, done_q, trig_q;
  logic             active;
  logic             cnt_ev, cnt_clr;
  logic             win_over;

  assign md = seq_mode_e'(mode);

  // effective limit: zero behaves as one
  function automatic logic [CW-1:0] eff_limit(input logic [CW-1:0] n);
    return (n == '0) ? {{(CW-1){1'b0}}, 1'b1} : n;
  endfunction

  // true when one more event reaches the limit
  function automatic logic reaches(input logic [CW-1:0] occ,
                                   input logic [CW-1:0] n);
    logic [CW:0] nxt;
    nxt = {1'b0, occ} + {{CW{1'b0}}, 1'b1};
    return nxt >= {1'b0, eff_limit(n)};
  endfunction

  function automatic logic [GW-1:0] gap_step(input logic [GW-1:0] g);
    return (g == '1) ? g : g + {{(GW-1){1'b0}}, 1'b1};
  endfunction

  assign active   = !done_q && (armed_q || !arm_en);
  assign qual     = strobe && active;
  assign win_over = elapsed > time_lim;

  // event selection for the occurrence-counting modes
  always_comb begin
    cnt_ev  = 1'b0;
    cnt_clr = 1'b0;
    case (md)
      MD_ANY, MD_STROBES: cnt_ev = qual;
      MD_P1_CNT:          cnt_ev = qual && m1;
      MD_P1_RUN: begin
        cnt_ev  = qual && m1;
        cnt_clr = qual && !m1;
      end
      MD_BOTH:            cnt_ev = qual && m1 && m2;
      MD_EITHER:          cnt_ev = qual && (m1 || m2);
      default: ;
    endcase
  end

  always_comb begin
    ph_n       = ph_q;
    occ_n      = occ_q;
    gap_n      = gap_q;
    fire       = 1'b0;
    load_stamp = 1'b0;

    if (cnt_ev) begin
      if (reaches(occ_q, count_n)) fire = 1'b1;
      else occ_n = occ_q + {{(CW-1){1'b0}}, 1'b1};
    end else if (cnt_clr) begin
      occ_n = '0;
    end

    case (md)
      MD_P1_THEN_P2: if (qual) begin
        if (ph_q == PH_WAIT) begin
          if (m1) ph_n = PH_SEEN;
        end else if (m2) fire = 1'b1;
      end
      MD_P1_NEXT_P2: if (qual) begin
        if (ph_q == PH_WAIT) begin
          if (m1) ph_n = PH_SEEN;
        end else if (!m1) begin
          if (m2) fire = 1'b1;
          else ph_n = PH_WAIT;
        end
      end
      MD_P1P2_GUARD: if (qual) begin
        if (ph_q == PH_WAIT) begin
          if (m1) ph_n = PH_SEEN;
        end else if (m3) begin
          ph_n = PH_WAIT;
        end else if (m2) begin
          ph_n = PH_WAIT;
          if (reaches(occ_q, count_n)) fire = 1'b1;
          else occ_n = occ_q + {{(CW-1){1'b0}}, 1'b1};
        end
      end
      MD_GAP_SHORT, MD_GAP_LONG: if (qual) begin
        if (ph_q == PH_WAIT) begin
          if (m1) begin
            ph_n  = PH_SEEN;
            gap_n = '0;
          end
        end else if (m2) begin
          if (md == MD_GAP_SHORT) fire = gap_q < {1'b0, count_n};
          else                    fire = gap_q > {1'b0, count_n};
          ph_n = PH_WAIT;
        end else if (m1) begin
          gap_n = '0;
        end else begin
          gap_n = gap_step(gap_q);
        end
      end
      MD_P2_EARLY, MD_P2_OVERDUE: begin
        if (ph_q == PH_WAIT) begin
          if (qual && m1) begin
            ph_n       = PH_SEEN;
            load_stamp = 1'b1;
          end
        end else if (active) begin
          if (md == MD_P2_EARLY) begin
            if (win_over)          ph_n = PH_WAIT;
            else if (qual && m2)   fire = 1'b1;
          end else begin
            if (win_over)          fire = 1'b1;
            else if (qual && m2)   ph_n = PH_WAIT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_WAIT;
      occ_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else if (restart) begin
      ph_q    <= PH_WAIT;
      occ_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      ph_q    <= fire ? PH_WAIT : ph_n;
      occ_q   <= fire ? '0 : occ_n;
      gap_q   <= gap_n;
      done_q  <= done_q || fire;
      trig_q  <= fire;
      if (arm) armed_q <= 1'b1;
    end
  end

  assign armed = armed_q;
  assign done  = done_q;
  assign trig  = trig_q;

endmodule

// File: rtl/seqtrig_top.sv
module seqtrig_top #(
  parameter int W  = 16,
  parameter int CW = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          arm_en,
  input  logic          arm,
  input  logic          strobe,
  input  logic [W-1:0]  bus,
  input  logic [3:0]    mode,
  input  logic [W-1:0]  p1_val,
  input  logic [W-1:0]  p1_msk,
  input  logic [W-1:0]  p2_val,
  input  logic [W-1:0]  p2_msk,
  input  logic [W-1:0]  p3_val,
  input  logic [W-1:0]  p3_msk,
  input  logic [CW-1:0] count_n,
  input  logic [TW-1:0] time_lim,
  output logic          trig
);

  localparam int NPAT = 3;

  logic [W-1:0]    pat_val [NPAT];
  logic [W-1:0]    pat_msk [NPAT];
  logic [NPAT-1:0] pat_hit;

  assign pat_val[0] = p1_val;
  assign pat_val[1] = p2_val;
  assign pat_val[2] = p3_val;
  assign pat_msk[0] = p1_msk;
  assign pat_msk[1] = p2_msk;
  assign pat_msk[2] = p3_msk;

  // R1: one masked comparator per pattern
  for (genvar gi = 0; gi < NPAT; gi++) begin : g_cmp
    seqtrig_cmp #(.W(W)) u_cmp (
      .bus (bus),
      .val (pat_val[gi]),
      .msk (pat_msk[gi]),
      .hit (pat_hit[gi])
    );
  end

  // internal events, named for the checker
  logic          m1, m2, m3;
  logic          load_stamp;
  logic          qual;
  logic          fire;
  logic          armed;
  logic          done;
  logic [TW-1:0] elapsed;

  assign m1 = pat_hit[0];
  assign m2 = pat_hit[1];
  assign m3 = pat_hit[2];

  seqtrig_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_stamp),
    .elapsed (elapsed)
  );

  seqtrig_fsm #(.CW(CW), .TW(TW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .arm_en     (arm_en),
    .arm        (arm),
    .strobe     (strobe),
    .mode       (mode),
    .m1         (m1),
    .m2         (m2),
    .m3         (m3),
    .count_n    (count_n),
    .time_lim   (time_lim),
    .elapsed    (elapsed),
    .load_stamp (load_stamp),
    .qual       (qual),
    .fire       (fire),
    .armed      (armed),
    .done       (done),
    .trig       (trig)
  );

endmodule

// File: rtl/seqtrig_chk.sv
module seqtrig_chk #(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          arm_en,
  input logic          strobe,
  input logic [3:0]    mode,
  input logic [TW-1:0] time_lim,
  input logic [TW-1:0] elapsed,
  input logic          armed,
  input logic          done,
  input logic          trig
);

  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r13_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);

  a_r13_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!done && !trig));

  a_r11_wait_for_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_en && !armed) |=> !trig);

  a_r12_strobe_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode) != 4'd10) |-> $past(strobe));

  a_r9_overdue_after_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode) == 4'd10) |-> ($past(elapsed) > $past(time_lim)));

endmodule

bind seqtrig_top seqtrig_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .restart  (restart),
  .arm_en   (arm_en),
  .strobe   (strobe),
  .mode     (mode),
  .time_lim (time_lim),
  .elapsed  (elapsed),
  .armed    (armed),
  .done     (done),
  .trig     (trig)
);

// File: tb/seqtrig_top_bench.sv
`timescale 1ns/1ps
module seqtrig_top_bench;
  localparam int W = 16, CW = 8, TW = 12;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, arm_en = 1'b0, arm = 1'b0, strobe = 1'b0;
  logic [W-1:0] bus = '0;
  logic [3:0] mode = '0;
  logic [W-1:0] p1_val = '0, p1_msk = '0, p2_val = '0, p2_msk = '0, p3_val = '0, p3_msk = '0;
  logic [CW-1:0] count_n = '0;
  logic [TW-1:0] time_lim = '0;
  logic trig;

  seqtrig_top #(.W(W), .CW(CW), .TW(TW)) u_seqtrig_top (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0, fails = 0, last_edge = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R13";
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every trigger must match the oldest expected edge
  always @(negedge clk) begin
    if (rst_n && trig) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected trig at edge %0d (expected none)", cur_tag, cyc);
      end else begin
        int e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s: trig at edge %0d, expected edge %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic drive(input logic [W-1:0] b, input logic s, input logic a,
                       input logic r, input bit exp_fire);
    @(negedge clk);
    bus = b; strobe = s; arm = a; restart = r;
    last_edge = cyc + 1;
    if (exp_fire) begin exp_q.push_back(cyc + 1); tag_q.push_back(cur_tag); end
  endtask

  task automatic step(input logic [W-1:0] b, input logic s, input bit f);
    drive(b, s, 1'b0, 1'b0, f);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0);
  endtask

  task automatic expect_at(input int e);
    exp_q.push_back(e); tag_q.push_back(cur_tag);
  endtask

  // a few more matching states after each case prove the hold-off (R13)
  task automatic close_case();
    step(p1_val, 1'b1, 1'b0);
    step(p2_val, 1'b1, 1'b0);
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d trig pulse(s) missing, expected edge %0d", tag_q[0], exp_q.size(), exp_q[0]);
      exp_q.delete(); tag_q.delete();
    end
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(1);
  endtask

  task automatic cfg(input logic [3:0] md, input int n, input int lim);
    mode = md; count_n = CW'(n); time_lim = TW'(lim);
    p1_val = 16'h00AA; p1_msk = 16'hFFFF;
    p2_val = 16'h00BB; p2_msk = 16'hFFFF;
    p3_val = 16'h00CC; p3_msk = 16'hFFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (trig !== 1'b0) begin fails++; $display("FAIL R13: reset trig=%b expected 0", trig); end

    // R2 + R12: any state, N=3, unstrobed cycles in between do not count
    cur_tag = "R2"; cfg(4'd0, 3, 0);
    step(16'h1234, 1, 0); step(16'h00AA, 0, 0); step(16'h5555, 1, 0);
    idle(2); step(16'h0000, 1, 1);
    close_case();
    cur_tag = "R2"; cfg(4'd1, 0, 0);
    step(16'h7777, 1, 1);
    close_case();

    // R3 + R12: non-adjacent first-pattern matches
    cur_tag = "R3"; cfg(4'd2, 3, 0);
    step(16'h00AA, 1, 0); step(16'h0011, 1, 0); step(16'h00AA, 1, 0);
    step(16'h00AA, 0, 0); step(16'h0022, 1, 0); step(16'h00AA, 1, 1);
    close_case();

    // R1: mask 0xFF00 compares only the upper byte
    cur_tag = "R1"; cfg(4'd2, 1, 0); p1_val = 16'h1234; p1_msk = 16'hFF00;
    step(16'h5534, 1, 0); step(16'h12FF, 1, 1);
    close_case();

    // R4: run broken by a non-match
    cur_tag = "R4"; cfg(4'd3, 3, 0);
    step(16'h00AA, 1, 0); step(16'h00AA, 1, 0); step(16'h0011, 1, 0);
    step(16'h00AA, 1, 0); step(16'h00AA, 1, 0); step(16'h00AA, 1, 1);
    close_case();

    // R5: second pattern before first is ignored
    cur_tag = "R5"; cfg(4'd4, 0, 0);
    step(16'h00BB, 1, 0); step(16'h00AA, 1, 0); step(16'h0011, 1, 0);
    step(16'h0022, 1, 0); step(16'h00BB, 1, 1);
    close_case();

    // R6: immediate successor must be the second pattern
    cur_tag = "R6"; cfg(4'd5, 0, 0);
    step(16'h00AA, 1, 0); step(16'h00AA, 1, 0); step(16'h0011, 1, 0);
    step(16'h00BB, 1, 0); step(16'h00AA, 1, 0); step(16'h00BB, 1, 1);
    close_case();

    // R7: guard cancels, two completions needed
    cur_tag = "R7"; cfg(4'd6, 2, 0);
    step(16'h00AA, 1, 0); step(16'h00BB, 1, 0);
    step(16'h00AA, 1, 0); step(16'h00CC, 1, 0); step(16'h00BB, 1, 0);
    step(16'h00AA, 1, 0); step(16'h0011, 1, 0); step(16'h00BB, 1, 1);
    close_case();

    // R8: gap below / above N=2
    cur_tag = "R8"; cfg(4'd7, 2, 0);
    step(16'h00AA, 1, 0); step(16'h0011, 1, 0); step(16'h0022, 1, 0); step(16'h00BB, 1, 0);
    step(16'h00AA, 1, 0); step(16'h0011, 1, 0); step(16'h00BB, 1, 1);
    close_case();
    cur_tag = "R8"; cfg(4'd8, 2, 0);
    step(16'h00AA, 1, 0); step(16'h0011, 1, 0); step(16'h00BB, 1, 0);
    step(16'h00AA, 1, 0); step(16'h0001, 1, 0); step(16'h0002, 1, 0);
    step(16'h0003, 1, 0); step(16'h00BB, 1, 1);
    close_case();

    // R9: early window, limit 5 (m=6 misses, m=5 fires)
    cur_tag = "R9"; cfg(4'd9, 0, 5);
    step(16'h00AA, 1, 0); idle(5); step(16'h00BB, 1, 0);
    step(16'h00AA, 1, 0); idle(4); step(16'h00BB, 1, 1);
    close_case();
    // R9: overdue, limit 4; early P2 cancels, then timeout fires at k+5
    cur_tag = "R9"; cfg(4'd10, 0, 4);
    step(16'h00AA, 1, 0); idle(1); step(16'h00BB, 1, 0); idle(3);
    step(16'h00AA, 1, 0); expect_at(last_edge + 5); idle(7);
    close_case();

    // R10: both / either with disjoint masks
    cur_tag = "R10"; cfg(4'd11, 2, 0);
    p1_val = 16'h00A0; p1_msk = 16'h00F0; p2_val = 16'h0005; p2_msk = 16'h000F;
    step(16'h00A5, 1, 0); step(16'h00A0, 1, 0); step(16'h0005, 1, 0);
    step(16'h00B5, 1, 0); step(16'h00A5, 1, 1);
    close_case();
    cur_tag = "R10"; cfg(4'd12, 3, 0);
    p1_val = 16'h00A0; p1_msk = 16'h00F0; p2_val = 16'h0005; p2_msk = 16'h000F;
    step(16'h00A0, 1, 0); step(16'h0033, 1, 0); step(16'h0005, 1, 0);
    step(16'h0077, 1, 0); step(16'h00A5, 1, 1);
    close_case();

    // R11: arming, arming edge not evaluated, restart disarms
    cur_tag = "R11"; cfg(4'd0, 1, 0); arm_en = 1'b1;
    step(16'h0001, 1, 0); step(16'h0002, 1, 0);
    drive(16'h0003, 1'b1, 1'b1, 1'b0, 1'b0);
    step(16'h0004, 1, 1);
    close_case();
    cur_tag = "R11";
    step(16'h0005, 1, 0); step(16'h0006, 1, 0);
    drive('0, 1'b0, 1'b1, 1'b0, 1'b0); step(16'h0007, 1, 1);
    close_case();
    arm_en = 1'b0;

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule